// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block sits behind the byte-level front end of a two-wire bus slave that drives a 10-bit digital-to-analog converter. The front end hands it decoded events, each a single-cycle pulse: an acknowledged command byte, an acknowledged low data byte, an acknowledged high data byte, a stop condition, a broadcast synchronisation quick command with its one-bit flag, and an abort. An abort means the transaction was cut short by a new start. The controller keeps two stages of registers. The input stage collects what the bus writes. The output stage drives the converter code, the reference-select line and the power-down line.

A stored sync-mode bit decides when data moves from the input stage to the output stage. With the bit clear, every stop condition moves it. With the bit set, only a broadcast sync event with its flag set moves it. This lets many converters on one bus be loaded one after another and then updated together. A broadcast sync event with its flag clear wipes both stages, whatever the mode. The code is committed to the input stage only when a full low-then-high data pair has arrived. A cut-short write therefore changes only the command.

Top module: `dac_reg_ctrl`

## Requirements
- R1: After reset the code output is 0, the reference select is 0 (supply), the power-down output is 0 and the sync-mode bit is 0 (update on stop).
- R2: In a command byte, bit 2 selects the internal reference when 1, bit 1 requests power-down when 1, and bit 0 sets sync mode when 1. Bits 7 to 3 have no effect on any output.
- R3: The code is the low data byte in bits 7..0 and bits 1..0 of the high data byte in bits 9..8. Bits 7..2 of the high byte have no effect.
- R4: With sync mode 0, a stop moves the input code and command to the outputs, which show them in the cycle after the stop pulse.
- R5: The outputs change only in the cycle after a transfer or a clear. Byte events alone never change them.
- R6: With sync mode 1, a stop leaves the outputs unchanged. A sync event with flag 1 performs the transfer, visible in the following cycle.
- R7: With sync mode 0, a sync event with flag 1 has no effect on the outputs.
- R8: A sync event with flag 0 clears the input and output registers in both modes, so the outputs read 0 in the next cycle and stay 0 after a later stop.
- R9: A command followed by a stop or an abort before the high data byte updates only the command. The input code keeps its earlier value.
- R10: A low byte that does not follow a command, or a high byte that does not follow a low byte, is ignored.
- R11: While power-down is active the stored code is kept. It reappears unchanged on the code output when power-down is released by a command-only write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Byte received with the current acknowledge event |
| cmd_ack_i | input | 1 | Command byte acknowledged |
| lo_ack_i | input | 1 | Low data byte acknowledged |
| hi_ack_i | input | 1 | High data byte acknowledged |
| stop_i | input | 1 | Stop condition seen |
| sync_i | input | 1 | Broadcast sync quick command acknowledged |
| sync_flag_i | input | 1 | Flag bit of the sync quick command (1 update, 0 clear) |
| abort_i | input | 1 | Transaction interrupted by a new start |
| dac_code_o | output | 10 | Output-stage converter code |
| vref_int_o | output | 1 | Output-stage reference select (1 internal) |
| shutdown_o | output | 1 | Output-stage power-down request |

## Verification
The hardest state to reach is a sync-mode transfer where the input stage holds data different from the output stage. The stimulus first commits a full write with sync mode set and stop pulses that must not move anything. Only then does it issue a flagged sync event, so a wrong transfer path shows at once. Cut-short writes and out-of-order data bytes are placed between complete writes that carry distinct code values, so a stray capture of a lone byte changes the visible code after the next transfer. A behavioural model tracks the expected outputs and is compared every cycle, including the idle cycles in which nothing may change.

// File: rtl/dac_reg_pkg.sv
package dac_reg_pkg;

    // Command byte bit positions decoded by the input stage
    localparam int CMD_REF_BIT  = 2;
    localparam int CMD_SHDN_BIT = 1;
    localparam int CMD_SYNC_BIT = 0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_LO   = 2'd2
    } phase_e;

    typedef struct packed {
        logic vref_int;
        logic shdn;
        logic sync_mode;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{vref_int: 1'b0, shdn: 1'b0, sync_mode: 1'b0};

endpackage

// File: rtl/dac_phase_trk.sv
module dac_phase_trk
    import dac_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_cmd,
    input  logic ev_lo,
    input  logic ev_hi,
    input  logic ev_end,
    output logic cap_cmd,
    output logic cap_lo,
    output logic cap_hi
);

    typedef struct packed {
        phase_e phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cap_cmd = ev_cmd;
        cap_lo  = ev_lo && (st_q.phase == PH_CMD);
        cap_hi  = ev_hi && (st_q.phase == PH_LO);
        if (ev_end) begin
            st_d.phase = PH_IDLE;
        end else if (cap_cmd) begin
            st_d.phase = PH_CMD;
        end else if (cap_lo) begin
            st_d.phase = PH_LO;
        end else if (cap_hi) begin
            st_d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE};
        else        st_q <= st_d;
    end

    // R10: a high byte is only taken right after an accepted low byte
    assert_hi_after_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hi |-> $past(cap_lo) || $past(st_q.phase == PH_LO))
        else $error("high byte accepted out of order");

endmodule

// File: rtl/dac_in_stage.sv
module dac_in_stage
    import dac_reg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_cmd,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic              ev_abort,
    input  logic [BYTE_W-1:0] byte_i,
    output ctl_t              ctl_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int HI_W = CODE_W - BYTE_W;

    typedef struct packed {
        ctl_t              ctl;
        logic [BYTE_W-1:0] lo;
        logic [CODE_W-1:0] code;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '{ctl: CTL_RESET, lo: '0, code: '0};
        end else begin
            if (cap_cmd) begin
                st_d.ctl.vref_int  = byte_i[CMD_REF_BIT];
                st_d.ctl.shdn      = byte_i[CMD_SHDN_BIT];
                st_d.ctl.sync_mode = byte_i[CMD_SYNC_BIT];
            end
            if (cap_lo) begin
                st_d.lo = byte_i;
            end
            if (cap_hi) begin
                st_d.code = {byte_i[HI_W-1:0], st_q.lo};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctl: CTL_RESET, lo: '0, code: '0};
        else        st_q <= st_d;
    end

    assign ctl_o  = st_q.ctl;
    assign code_o = st_q.code;

    // R9: an interrupted transaction never alters the committed input code
    assert_keep_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_abort && !clr) |=> $stable(code_o))
        else $error("abort changed the input code");

endmodule

// File: rtl/dac_upd_ctrl.sv
module dac_upd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_stop,
    input  logic ev_sync,
    input  logic sync_flag,
    input  logic sync_mode,
    output logic xfer,
    output logic clr
);

    always_comb begin
        clr  = ev_sync && !sync_flag;
        xfer = 1'b0;
        if (!clr) begin
            if (sync_mode) xfer = ev_sync && sync_flag;
            else           xfer = ev_stop;
        end
    end

    // R7: a flagged sync in stop-update mode moves nothing
    assert_sync_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sync && sync_flag && !sync_mode) |-> !xfer)
        else $error("sync transferred in stop mode");

    // R6: a stop in sync mode moves nothing
    assert_stop_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && sync_mode) |-> !xfer)
        else $error("stop transferred in sync mode");

endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic              clr,
    input  logic              in_ref,
    input  logic              in_shdn,
    input  logic [CODE_W-1:0] in_code,
    output logic [CODE_W-1:0] code_o,
    output logic              ref_o,
    output logic              shdn_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              vref;
        logic              shdn;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '{code: '0, vref: 1'b0, shdn: 1'b0};
        end else if (xfer) begin
            st_d = '{code: in_code, vref: in_ref, shdn: in_shdn};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{code: '0, vref: 1'b0, shdn: 1'b0};
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign ref_o  = st_q.vref;
    assign shdn_o = st_q.shdn;

    // R5: without a strobe every output holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer || clr) |=> ($stable(code_o) && $stable(ref_o) && $stable(shdn_o)))
        else $error("output changed without strobe");

    // R8: a clear drives all outputs to zero
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code_o == '0 && !ref_o && !shdn_o))
        else $error("clear did not zero outputs");

endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
    import dac_reg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              cmd_ack_i,
    input  logic              lo_ack_i,
    input  logic              hi_ack_i,
    input  logic              stop_i,
    input  logic              sync_i,
    input  logic              sync_flag_i,
    input  logic              abort_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              vref_int_o,
    output logic              shutdown_o
);

    logic              cap_cmd, cap_lo, cap_hi;
    logic              xfer, clr;
    logic              ev_end;
    ctl_t              in_ctl;
    logic [CODE_W-1:0] in_code;

    assign ev_end = stop_i || sync_i || abort_i;

    dac_phase_trk u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_cmd  (cmd_ack_i),
        .ev_lo   (lo_ack_i),
        .ev_hi   (hi_ack_i),
        .ev_end  (ev_end),
        .cap_cmd (cap_cmd),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi)
    );

    dac_in_stage #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .cap_cmd  (cap_cmd),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .ev_abort (abort_i),
        .byte_i   (byte_i),
        .ctl_o    (in_ctl),
        .code_o   (in_code)
    );

    dac_upd_ctrl u_upd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_stop   (stop_i),
        .ev_sync   (sync_i),
        .sync_flag (sync_flag_i),
        .sync_mode (in_ctl.sync_mode),
        .xfer      (xfer),
        .clr       (clr)
    );

    dac_out_stage #(.CODE_W(CODE_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .clr     (clr),
        .in_ref  (in_ctl.vref_int),
        .in_shdn (in_ctl.shdn),
        .in_code (in_code),
        .code_o  (dac_code_o),
        .ref_o   (vref_int_o),
        .shdn_o  (shutdown_o)
    );

    // R10: the front end presents at most one event per cycle
    assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ack_i, lo_ack_i, hi_ack_i, stop_i, sync_i, abort_i}))
        else $error("several bus events in one cycle");

    // R4: in stop-update mode a stop shows the input code next cycle
    assert_stop_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !in_ctl.sync_mode) |=> (dac_code_o == $past(in_code)))
        else $error("stop did not update code");

endmodule

// File: tb/test_dac_reg_ctrl.sv
module test_dac_reg_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_i = '0;
    logic       cmd_ack_i = 0, lo_ack_i = 0, hi_ack_i = 0;
    logic       stop_i = 0, sync_i = 0, sync_flag_i = 0, abort_i = 0;
    logic [9:0] dac_code_o;
    logic       vref_int_o, shutdown_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_cmd = 0, m_lo = 0, m_code = 0, m_ph = 0;
    int o_code = 0, o_cmd = 0;

    always #10 clk = ~clk;

    dac_reg_ctrl i_dac_reg_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_i(byte_i),
        .cmd_ack_i(cmd_ack_i), .lo_ack_i(lo_ack_i), .hi_ack_i(hi_ack_i),
        .stop_i(stop_i), .sync_i(sync_i), .sync_flag_i(sync_flag_i),
        .abort_i(abort_i), .dac_code_o(dac_code_o),
        .vref_int_o(vref_int_o), .shutdown_o(shutdown_o)
    );

    task automatic compare(input string req);
        int e_ref, e_sd;
        e_ref = (o_cmd >> 2) & 1;
        e_sd  = (o_cmd >> 1) & 1;
        checks++;
        if (int'(dac_code_o) != o_code || int'(vref_int_o) != e_ref || int'(shutdown_o) != e_sd) begin
            errors++;
            $display("FAIL %s: code=%0h ref=%0d sd=%0d expected code=%0h ref=%0d sd=%0d",
                     req, dac_code_o, vref_int_o, shutdown_o, o_code, e_ref, e_sd);
        end
    endtask

    // kind: 0 idle, 1 cmd, 2 lo, 3 hi, 4 stop, 5 sync, 6 abort
    task automatic step(input int kind, input int b, input int flag, input string req);
        byte_i      = 8'(b);
        cmd_ack_i   = (kind == 1);
        lo_ack_i    = (kind == 2);
        hi_ack_i    = (kind == 3);
        stop_i      = (kind == 4);
        sync_i      = (kind == 5);
        sync_flag_i = 1'(flag);
        abort_i     = (kind == 6);
        @(posedge clk);
        case (kind)
            1: begin m_cmd = b % 8; m_ph = 1; end
            2: if (m_ph == 1) begin m_lo = b; m_ph = 2; end
            3: if (m_ph == 2) begin m_code = (b % 4) * 256 + m_lo; m_ph = 0; end
            4: begin
                m_ph = 0;
                if (m_cmd % 2 == 0) begin o_code = m_code; o_cmd = m_cmd; end
            end
            5: begin
                m_ph = 0;
                if (flag == 0) begin
                    m_cmd = 0; m_lo = 0; m_code = 0; o_code = 0; o_cmd = 0;
                end else if (m_cmd % 2 == 1) begin
                    o_code = m_code; o_cmd = m_cmd;
                end
            end
            6: m_ph = 0;
            default: ;
        endcase
        @(negedge clk);
        cmd_ack_i = 0; lo_ack_i = 0; hi_ack_i = 0;
        stop_i = 0; sync_i = 0; abort_i = 0;
        compare(req);
    endtask

    task automatic write_word(input int c, input int lo, input int hi, input string req);
        step(1, c, 0, req);
        step(2, lo, 0, req);
        step(3, hi, 0, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset release");

        // R2 R3 R4: upper command bits ignored, high byte upper bits ignored
        write_word(8'hF8, 8'h5A, 8'hFD, "R5 bytes only");
        step(0, 0, 0, "R5 idle before stop");
        step(4, 0, 0, "R4 R3 R2 stop update");
        if (dac_code_o != 10'h15A) begin
            errors++; $display("FAIL R3: code=%0h expected 15a", dac_code_o);
        end
        checks++;

        // R11: shutdown with internal reference, then release keeps code
        write_word(8'h06, 8'h33, 8'h02, "R2 shutdown write");
        step(4, 0, 0, "R11 shutdown at stop");
        step(1, 8'h00, 0, "R9 command only");
        step(4, 0, 0, "R11 release keeps code");

        // R6: sync mode holds stops, sync flag 1 transfers
        write_word(8'h01, 8'hFF, 8'h03, "R6 sync-mode write");
        step(4, 0, 0, "R6 stop held");
        step(4, 0, 0, "R6 second stop held");
        step(5, 0, 1, "R6 sync transfer");

        // R7: stop mode, sync flag 1 has no effect
        step(1, 8'h04, 0, "R9 send byte");
        step(4, 0, 0, "R4 ref update");
        write_word(8'h00, 8'h11, 8'h00, "R7 load");
        step(5, 0, 1, "R7 sync ignored");

        // R9: interrupted write keeps code
        step(4, 0, 0, "R4 commit 011");
        step(1, 8'h00, 0, "R9 cmd");
        step(2, 8'h44, 0, "R9 lo");
        step(6, 0, 0, "R9 abort");
        step(4, 0, 0, "R9 code kept after abort");
        step(1, 8'h02, 0, "R9 cmd");
        step(2, 8'h66, 0, "R9 lo");
        step(4, 0, 0, "R9 stop before hi");

        // R10: out-of-order bytes ignored
        step(2, 8'h77, 0, "R10 lone lo");
        step(3, 8'h01, 0, "R10 lone hi");
        step(1, 8'h00, 0, "R10 cmd");
        step(3, 8'h02, 0, "R10 hi without lo");
        step(4, 0, 0, "R10 code unchanged");

        // R8: clear in sync mode, then stop still shows zeros
        write_word(8'h05, 8'h99, 8'h01, "R8 load");
        step(5, 0, 1, "R8 pre transfer");
        step(5, 0, 0, "R8 clear");
        step(4, 0, 0, "R8 stop after clear");
        write_word(8'h00, 8'h12, 8'h03, "R8 reload");
        step(5, 0, 0, "R8 clear in stop mode");
        step(4, 0, 0, "R8 inputs cleared");

        repeat (3) step(0, 0, 0, "R5 idle");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule